// File: doc/BRIEF.md
# Single-Frame Receive Buffer with Read-Out Auto-Flush

This block stores one received frame and hands it to a host over register reads. The baseband side writes the frame one byte at a time. The first byte is a length value giving the number of payload bytes, and the payload bytes follow it. A separate end-of-frame strobe then arrives, carrying a pass/fail flag from the integrity check. A frame that passes every check is kept in the buffer, and the receive-done flag is set.

The host drains the frame with read strobes. The read data port shows the byte at the read pointer, and each strobe moves the pointer on by one. The buffer empties itself at the point where the host consumes the final payload byte. The host can also empty the buffer at any time with a one-shot flush command. While a frame is waiting, any new incoming frame is thrown away and a sticky overflow flag is raised.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, `irqStatus` is 0x00 and `hostRdData` is 0x00.
- R2: A frame is accepted when all of the following hold: `rxFrameOk` is 1 when `rxFrameEnd` pulses, the length byte L is between 1 and MAX_LEN, and exactly L+1 bytes were written. On acceptance, bit 3 of `irqStatus` is set on the clock edge that samples `rxFrameEnd`. Successive host reads then return L followed by the payload in arrival order.
- R3: The read that consumes the final payload byte empties the buffer. Later reads return 0x00, and the next frame is accepted.
- R4: A read while the buffer holds no frame returns 0x00 and moves no pointer. The first read after a later frame arrives returns that frame's length byte.
- R5: A frame that ends with `rxFrameOk` = 0 is discarded. No interrupt is raised, reads return 0x00, and the next frame is accepted.
- R6: A frame with L = 0 is discarded as in R5. The same applies when L > MAX_LEN or when the byte count differs from L+1.
- R7: A register write to address 0x0D with data bit 0 set empties the buffer at once. A write there with bit 0 clear has no effect. Any partly received frame at the moment of the flush is also discarded.
- R8: Bytes that arrive while a frame is held are dropped, and the held frame is kept intact. Each such byte sets the sticky overflow flag, `irqStatus` bit 4.
- R9: A register write to address 0x31 clears `irqStatus` bit 3 where data bit 3 is 1, and clears bit 4 where data bit 4 is 1. Zero bits in the data, and writes to other addresses, leave both flags unchanged.
- R10: A frame of the maximum size, L = MAX_LEN, is accepted and read back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxByteValid | input | 1 | Strobe that qualifies one incoming frame byte |
| rxByte | input | 8 | Incoming frame byte; the first byte of a frame is the length |
| rxFrameEnd | input | 1 | End-of-frame strobe |
| rxFrameOk | input | 1 | Integrity-check result, sampled together with `rxFrameEnd` |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 8 | Host register write address |
| regWrData | input | 8 | Host register write data |
| hostRdEn | input | 1 | Host read strobe; advances the read pointer |
| hostRdData | output | 8 | Byte at the read pointer, or 0x00 when no frame is held |
| irqStatus | output | 8 | Bit 3 receive-done, bit 4 overflow, all other bits 0 |

## Verification
The bench builds the block with MAX_LEN = 12. With that value, the longest legal frame, the first oversize length (13) and byte counts beyond the storage depth all fall within the random length range of 0 to 14. A random frame, its read-out and the interrupt clear take only a few dozen cycles, so a large share of each class turns up across the random frames. The directed cases cover the remaining corners: a frame arriving during a hold, a flush in the middle of a frame, and writes to the clear and flush bits with the relevant bit at 0.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

  localparam logic [7:0] ADDR_IRQ  = 8'h31;
  localparam logic [7:0] ADDR_CTRL = 8'h0D;
  localparam int DONE_BIT  = 3;
  localparam int OVF_BIT   = 4;
  localparam int FLUSH_BIT = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic store;      // write incoming byte at write pointer
    logic wrRewind;   // drop partial frame
    logic rdAdvance;  // step read pointer
    logic clearAll;   // empty buffer (flush)
  } dpStrobe_t;

endpackage

// File: rtl/rx_frame_dpath.sv
module rx_frame_dpath
  import rx_frame_pkg::*;
#(
  parameter int MAX_LEN = 128,
  parameter int PTR_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        stb,
  input  logic [7:0]       wrData,
  input  logic             holding,
  output logic [PTR_W-1:0] wrCount,
  output logic [PTR_W-1:0] rdPtr,
  output logic [7:0]       lenByte,
  output logic [7:0]       rdData
);

  localparam int DEPTH = MAX_LEN + 1;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.store) mem[wrCount] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrCount <= '0;
      rdPtr   <= '0;
    end else begin
      if (stb.clearAll || stb.wrRewind) wrCount <= '0;
      else if (stb.store)               wrCount <= wrCount + 1'b1;

      if (stb.clearAll)       rdPtr <= '0;
      else if (stb.rdAdvance) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign lenByte = mem[0];
  assign rdData  = holding ? mem[rdPtr] : 8'h00;

  // R2: the read pointer never runs past the stored length while held
  p_rdptr_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> (32'(rdPtr) <= 32'(lenByte)));

  // R7: a clear leaves both pointers at zero
  p_clear_rewinds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clearAll |=> (rdPtr == '0 && wrCount == '0));

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_frame_pkg::*;
#(
  parameter int MAX_LEN = 128,
  parameter int PTR_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrValid,
  input  logic             wrEnd,
  input  logic             wrOk,
  input  logic             regWrEn,
  input  logic [7:0]       regAddr,
  input  logic [7:0]       regWrData,
  input  logic             hostRdEn,
  input  logic [PTR_W-1:0] wrCount,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [7:0]       lenByte,
  output dpStrobe_t        stb,
  output logic             holding,
  output logic             doneFlag,
  output logic             ovfFlag
);

  localparam int DEPTH = MAX_LEN + 1;

  logic dropping, badFrame;
  logic flushCmd, clrDone, clrOvf, lastRead, accepting, roomLeft, frameGood, acceptNow;

  assign flushCmd  = regWrEn && (regAddr == ADDR_CTRL) && regWrData[FLUSH_BIT];
  assign clrDone   = regWrEn && (regAddr == ADDR_IRQ) && regWrData[DONE_BIT];
  assign clrOvf    = regWrEn && (regAddr == ADDR_IRQ) && regWrData[OVF_BIT];
  assign lastRead  = hostRdEn && holding && (32'(rdPtr) == 32'(lenByte));
  assign accepting = !holding && !dropping;
  assign roomLeft  = 32'(wrCount) < DEPTH;
  assign frameGood = wrOk && !badFrame && (lenByte != 8'h00)
                     && (32'(lenByte) <= MAX_LEN)
                     && (32'(wrCount) == 32'(lenByte) + 1);
  assign acceptNow = accepting && wrEnd && frameGood && !flushCmd;

  always_comb begin
    stb           = '0;
    stb.store     = accepting && wrValid && roomLeft && !flushCmd;
    stb.rdAdvance = hostRdEn && holding && !lastRead && !flushCmd;
    stb.clearAll  = flushCmd || lastRead;
    stb.wrRewind  = accepting && wrEnd && !frameGood && !flushCmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holding  <= 1'b0;
      doneFlag <= 1'b0;
      ovfFlag  <= 1'b0;
      dropping <= 1'b0;
      badFrame <= 1'b0;
    end else begin
      if (flushCmd || lastRead) holding <= 1'b0;
      else if (acceptNow)       holding <= 1'b1;

      if (acceptNow)    doneFlag <= 1'b1;
      else if (clrDone) doneFlag <= 1'b0;

      if (wrValid && holding) ovfFlag <= 1'b1;
      else if (clrOvf)        ovfFlag <= 1'b0;

      if (wrEnd) dropping <= 1'b0;
      else if ((wrValid && holding) || (flushCmd && !holding && wrCount != '0))
        dropping <= 1'b1;

      if (wrEnd || flushCmd) badFrame <= 1'b0;
      else if (accepting && wrValid && !roomLeft) badFrame <= 1'b1;
    end
  end

  // R3: consuming the final payload byte returns the read pointer to zero
  p_last_read_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRdEn && holding && 32'(rdPtr) == 32'(lenByte)) |=> (rdPtr == '0 && !holding));

  // R7: a flush command empties the buffer on the next cycle
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flushCmd |=> (!holding && wrCount == '0));

  // R8: a byte arriving during a hold raises overflow
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && holding) |=> ovfFlag);

  // R2: the done flag only rises after a passing end-of-frame
  p_done_needs_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(wrEnd && wrOk));

  // R5: a failing frame never raises the done flag
  p_bad_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEnd && !wrOk && !doneFlag) |=> !doneFlag);

endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rx_frame_pkg::*;
#(
  parameter int MAX_LEN = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxByteValid,
  input  logic [7:0] rxByte,
  input  logic       rxFrameEnd,
  input  logic       rxFrameOk,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       hostRdEn,
  output logic [7:0] hostRdData,
  output logic [7:0] irqStatus
);

  localparam int PTR_W = $clog2(MAX_LEN + 2);

  dpStrobe_t        stb;
  logic             holding, doneFlag, ovfFlag;
  logic [PTR_W-1:0] wrCount, rdPtr;
  logic [7:0]       lenByte;

  rx_frame_ctrl #(.MAX_LEN(MAX_LEN), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wrValid(rxByteValid), .wrEnd(rxFrameEnd), .wrOk(rxFrameOk),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .hostRdEn(hostRdEn),
    .wrCount(wrCount), .rdPtr(rdPtr), .lenByte(lenByte),
    .stb(stb), .holding(holding), .doneFlag(doneFlag), .ovfFlag(ovfFlag)
  );

  rx_frame_dpath #(.MAX_LEN(MAX_LEN), .PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .stb(stb), .wrData(rxByte), .holding(holding),
    .wrCount(wrCount), .rdPtr(rdPtr), .lenByte(lenByte), .rdData(hostRdData)
  );

  always_comb begin
    irqStatus           = 8'h00;
    irqStatus[DONE_BIT] = doneFlag;
    irqStatus[OVF_BIT]  = ovfFlag;
  end

endmodule

// File: tb/rx_frame_buffer_bench.sv
module rx_frame_buffer_bench;

  localparam int MAX = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxByteValid = 1'b0, rxFrameEnd = 1'b0, rxFrameOk = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       regWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00;
  logic [7:0] hostRdData, irqStatus;

  int tests = 0;
  int fails = 0;
  logic [7:0] frm [MAX+4];

  always #2.5 clk = ~clk;

  rx_frame_buffer #(.MAX_LEN(MAX)) u_rx_frame_buffer (
    .clk(clk), .rst_n(rst_n),
    .rxByteValid(rxByteValid), .rxByte(rxByte),
    .rxFrameEnd(rxFrameEnd), .rxFrameOk(rxFrameOk),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .irqStatus(irqStatus)
  );

  function automatic bit frameValid(int len, int count, bit ok);
    return ok && len >= 1 && len <= MAX && count == len + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic readByte(output logic [7:0] v);
    v = hostRdData;
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic regWrite(logic [7:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic fillFrame(int len, int count);
    frm[0] = 8'(len);
    for (int i = 1; i < count; i++) frm[i] = 8'($urandom_range(0, 255));
  endtask

  task automatic pushBytes(int first, int last);
    for (int i = first; i < last; i++) begin
      rxByteValid = 1'b1; rxByte = frm[i];
      @(negedge clk);
      rxByteValid = 1'b0;
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
  endtask

  task automatic endFrame(bit ok);
    rxFrameEnd = 1'b1; rxFrameOk = ok;
    @(negedge clk);
    rxFrameEnd = 1'b0; rxFrameOk = 1'b0;
  endtask

  task automatic sendFrame(int len, int count, bit ok);
    fillFrame(len, count);
    pushBytes(0, count);
    endFrame(ok);
  endtask

  task automatic readAll(string req, int len);
    logic [7:0] v;
    for (int i = 0; i <= len; i++) begin
      readByte(v);
      check(req, v, frm[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 irq", irqStatus, 8'h00);
    check("R1 rdData", hostRdData, 8'h00);

    // R4: reads while empty return 0 and do not move the pointer
    readByte(v); check("R4 empty", v, 0);
    readByte(v); check("R4 empty", v, 0);
    sendFrame(3, 4, 1'b1);
    check("R2 done", irqStatus[3], 1);
    readAll("R4 first read is length", 3);
    readByte(v); check("R3 after last", v, 0);
    regWrite(8'h31, 8'h08);
    check("R9 clear done", irqStatus[3], 0);

    // R10: maximum size frame
    sendFrame(MAX, MAX + 1, 1'b1);
    check("R10 done", irqStatus[3], 1);
    readAll("R10 data", MAX);
    readByte(v); check("R10 emptied", v, 0);
    regWrite(8'h31, 8'h08);

    // R6: explicit length corner cases
    sendFrame(0, 1, 1'b1);
    check("R6 zero length", irqStatus[3], 0);
    sendFrame(MAX + 1, MAX + 2, 1'b1);
    check("R6 oversize", irqStatus[3], 0);
    readByte(v); check("R6 nothing held", v, 0);

    // R8: frame arriving during a hold
    sendFrame(4, 5, 1'b1);
    regWrite(8'h31, 8'h08);
    begin
      logic [7:0] keep [MAX+4];
      for (int i = 0; i < 5; i++) keep[i] = frm[i];
      sendFrame(2, 3, 1'b1);
      check("R8 overflow set", irqStatus[4], 1);
      check("R8 no new done", irqStatus[3], 0);
      for (int i = 0; i < 5; i++) frm[i] = keep[i];
    end
    readAll("R8 held frame intact", 4);
    readByte(v); check("R8 emptied", v, 0);
    regWrite(8'h31, 8'h00);
    check("R9 zero write keeps ovf", irqStatus[4], 1);
    regWrite(8'h30, 8'h18);
    check("R9 other addr keeps ovf", irqStatus[4], 1);
    regWrite(8'h31, 8'h10);
    check("R9 clear ovf", irqStatus[4], 0);

    // R7: flush command
    sendFrame(5, 6, 1'b1);
    regWrite(8'h0D, 8'h00);
    readByte(v); check("R7 bit0 clear no effect", v, 5);
    regWrite(8'h0D, 8'h01);
    readByte(v); check("R7 flushed", v, 0);
    check("R7 done kept", irqStatus[3], 1);
    regWrite(8'h31, 8'h08);
    sendFrame(2, 3, 1'b1);
    readAll("R7 next frame after flush", 2);

    // R7: flush in the middle of a frame discards its tail
    regWrite(8'h31, 8'h08);
    fillFrame(5, 6);
    pushBytes(0, 3);
    regWrite(8'h0D, 8'h01);
    pushBytes(3, 6);
    endFrame(1'b1);
    check("R7 mid-frame flush no done", irqStatus[3], 0);
    readByte(v); check("R7 mid-frame flush empty", v, 0);

    // R5: failing check
    sendFrame(3, 4, 1'b0);
    check("R5 no done", irqStatus[3], 0);
    readByte(v); check("R5 discarded", v, 0);

    // random frames
    for (int n = 0; n < 60; n++) begin
      int len, count;
      bit ok, good;
      len   = $urandom_range(0, MAX + 2);
      count = ($urandom_range(0, 3) == 0) ? $urandom_range(1, MAX + 3) : len + 1;
      ok    = ($urandom_range(0, 7) != 0);
      good  = frameValid(len, count, ok);
      sendFrame(len, count, ok);
      check("R2/R5/R6 done flag", irqStatus[3], good);
      if (good) begin
        readAll("R2 random data", len);
        readByte(v); check("R3 random emptied", v, 0);
        regWrite(8'h31, 8'h08);
        check("R9 random clear", irqStatus[3], 0);
      end else begin
        readByte(v); check("R5/R6 random discarded", v, 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule